// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory through supply loss and return. Two comparator flags, already brought into the clock domain, tell it whether the supply sits below the deselect threshold and whether it has sunk further, below the lower battery switchover threshold. A third input reports that a memory access is in flight. From these the block drives three registered controls: a write-protect/deselect line that makes the memory ignore its control, address and data inputs, an output-disable line that forces the memory's data pins to high impedance, and a battery-select line for the power switch.

Both comparator flags are debounced: a flag must hold a new level for `FILT_LEN` consecutive clock samples before the sequencer reacts. The protect delay and the recovery hold-off are given in microseconds and turned into cycle counts from the `CLK_HZ` parameter. Protection is deferred while an access is in flight, but only up to the protect delay. After the supply returns, protection is held for the whole hold-off time, and reset enters the same path.

The five states are NORMAL, PENDING, PROTECTED, BATTERY and RECOVERY. Transitions: NORMAL→PENDING (low supply while an access runs), NORMAL→PROTECTED (low supply with the bus idle, or with the switchover flag already set), PENDING→PROTECTED (access ended, protect delay expired, or switchover flag set), PROTECTED→BATTERY (switchover flag set), BATTERY→PROTECTED (switchover flag clear), PROTECTED→RECOVERY (deselect flag clear), RECOVERY→PROTECTED (either flag set again), RECOVERY→NORMAL (hold-off expired).

Top module: `pwrfail_guard`

## Requirements
- R1: A comparator flag that takes a new level for fewer than `FILT_LEN` consecutive samples has no effect on any output. A level held for `FILT_LEN` samples takes effect at the `FILT_LEN`-th sampling edge.
- R2: While reset is active, and right after it, write-protect and output-disable are 1 and battery-select is 0. With both flags clear, protection drops only after the full recovery hold-off has run.
- R3: In NORMAL with no access in flight, a debounced low-supply flag moves the block to PROTECTED on the next edge.
- R4: In NORMAL with an access in flight, a debounced low-supply flag moves the block to PENDING with protection still off. Protection asserts on the first edge that samples the access-busy input low.
- R5: If the access is still in flight, protection asserts exactly `PROTECT_CYC` cycles after PENDING is entered, where `PROTECT_CYC = CLK_HZ*PROTECT_US/1e6`.
- R6: A debounced switchover flag during PENDING forces protection on the next edge, without waiting for the access or the protect delay. This covers a supply that falls fast through the threshold band.
- R7: Battery-select asserts only from PROTECTED, one edge after the debounced switchover flag is seen, and only while write-protect is also asserted.
- R8: When the debounced switchover flag clears in BATTERY, battery-select drops on the next edge and write-protect stays asserted.
- R9: After the debounced low-supply flag clears, write-protect stays 1 through the RECOVERY state for `RECOVER_CYC = CLK_HZ*RECOVER_US/1e6` cycles, then drops to 0 together with output-disable.
- R10: A debounced low-supply flag during RECOVERY returns the block to PROTECTED. The next RECOVERY restarts the hold-off from its full length.
- R11: Output-disable is asserted in every cycle in which write-protect is asserted, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlow_i | input | 1 | Synchronized flag: supply below the deselect threshold |
| vbat_i | input | 1 | Synchronized flag: supply below the battery switchover threshold |
| busy_i | input | 1 | A memory access is in flight |
| wprot_o | output | 1 | Write-protect/deselect for the memory |
| odis_o | output | 1 | Forces the memory's data outputs to high impedance |
| batsel_o | output | 1 | Selects the battery as the memory's supply |

## Verification
The bench builds the block with `CLK_HZ` = 100 000, `PROTECT_US` = 100 and `RECOVER_US` = 400, which gives a 10-cycle protect delay and a 40-cycle hold-off. It uses `FILT_LEN` = 3. At these values the protect-delay expiry, a fast fall overtaking that delay, and a restart of the hold-off partway through are all reached within a few hundred cycles. Each expected edge is checked one cycle early and at the edge itself. A two-sample glitch, one sample short of the filter length, shows the debounce boundary.

// File: rtl/pwrfail_guard_pkg.sv
package pwrfail_guard_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_PENDING   = 3'd1,
        ST_PROTECTED = 3'd2,
        ST_BATTERY   = 3'd3,
        ST_RECOVERY  = 3'd4
    } pfg_state_e;

    // Microseconds to clock cycles, computed in 64 bits to avoid overflow.
    function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
        longint unsigned prod;
        prod = longint'(hz) * longint'(us);
        return int'(prod / 64'd1000000);
    endfunction

endpackage

// File: rtl/pwrfail_guard_filter.sv
module pwrfail_guard_filter #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            clean_o <= 1'b0;
        end else if (raw_i == clean_o) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q   <= '0;
            clean_o <= raw_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwrfail_guard_timer.sv
module pwrfail_guard_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwrfail_guard_fsm.sv
module pwrfail_guard_fsm
    import pwrfail_guard_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter int unsigned PROT_LOAD = 1,
    parameter int unsigned REC_LOAD  = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vlow_f,
    input  logic         vbat_f,
    input  logic         busy_i,
    input  logic         tmr_done_i,
    output logic         tmr_load_o,
    output logic [W-1:0] tmr_val_o,
    output logic         wprot_o,
    output logic         odis_o,
    output logic         batsel_o
);
    pfg_state_e st_q, st_nxt;

    always_comb begin
        st_nxt     = st_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (st_q)
            ST_NORMAL: begin
                if (vlow_f) begin
                    if (busy_i && !vbat_f) begin
                        st_nxt     = ST_PENDING;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = W'(PROT_LOAD);
                    end else begin
                        st_nxt = ST_PROTECTED;
                    end
                end
            end
            ST_PENDING: begin
                if (!busy_i || vbat_f || tmr_done_i) begin
                    st_nxt = ST_PROTECTED;
                end
            end
            ST_PROTECTED: begin
                if (vbat_f) begin
                    st_nxt = ST_BATTERY;
                end else if (!vlow_f) begin
                    st_nxt     = ST_RECOVERY;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = W'(REC_LOAD);
                end
            end
            ST_BATTERY: begin
                if (!vbat_f) begin
                    st_nxt = ST_PROTECTED;
                end
            end
            ST_RECOVERY: begin
                if (vlow_f || vbat_f) begin
                    st_nxt = ST_PROTECTED;
                end else if (tmr_done_i) begin
                    st_nxt = ST_NORMAL;
                end
            end
            default: st_nxt = ST_PROTECTED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_PROTECTED;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wprot_o  <= 1'b1;
            odis_o   <= 1'b1;
            batsel_o <= 1'b0;
        end else begin
            wprot_o  <= (st_nxt != ST_NORMAL) && (st_nxt != ST_PENDING);
            odis_o   <= (st_nxt != ST_NORMAL) && (st_nxt != ST_PENDING);
            batsel_o <= (st_nxt == ST_BATTERY);
        end
    end

endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
    import pwrfail_guard_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PROTECT_US = 120,
    parameter int unsigned RECOVER_US = 60_000,
    parameter int unsigned FILT_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_i,
    input  logic vbat_i,
    input  logic busy_i,
    output logic wprot_o,
    output logic odis_o,
    output logic batsel_o
);
    localparam int unsigned PROTECT_CYC = us_to_cycles(CLK_HZ, PROTECT_US);
    localparam int unsigned RECOVER_CYC = us_to_cycles(CLK_HZ, RECOVER_US);
    localparam int unsigned MAX_CYC     = (PROTECT_CYC > RECOVER_CYC) ? PROTECT_CYC : RECOVER_CYC;
    localparam int unsigned TW          = $clog2(MAX_CYC + 1);
    localparam int unsigned NFLAG       = 2;

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] clean_flags;
    logic             vlow_f;
    logic             vbat_f;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;

    assign raw_flags = {vbat_i, vlow_i};
    assign vlow_f    = clean_flags[0];
    assign vbat_f    = clean_flags[1];

    for (genvar g = 0; g < NFLAG; g++) begin : g_flt
        pwrfail_guard_filter #(
            .LEN (FILT_LEN)
        ) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_flags[g]),
            .clean_o (clean_flags[g])
        );
    end

    pwrfail_guard_timer #(
        .W (TW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    pwrfail_guard_fsm #(
        .W         (TW),
        .PROT_LOAD (PROTECT_CYC - 1),
        .REC_LOAD  (RECOVER_CYC - 1)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vlow_f     (vlow_f),
        .vbat_f     (vbat_f),
        .busy_i     (busy_i),
        .tmr_done_i (tmr_done),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .wprot_o    (wprot_o),
        .odis_o     (odis_o),
        .batsel_o   (batsel_o)
    );

endmodule

// File: rtl/pwrfail_guard_checker.sv
module pwrfail_guard_checker #(
    parameter int unsigned PROTECT_CYC = 10,
    parameter int unsigned RECOVER_CYC = 40
) (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic vlow_f,
    input logic vbat_f,
    input logic wprot_o,
    input logic odis_o,
    input logic batsel_o
);
    localparam int unsigned PW = $clog2(PROTECT_CYC + 3) + 1;
    localparam int unsigned RW = $clog2(RECOVER_CYC + 3) + 1;

    logic [PW-1:0] pend_run;
    logic [RW-1:0] hold_run;

    // Cycles of low supply seen while still unprotected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_run <= '0;
        end else if (vlow_f && !wprot_o) begin
            if (pend_run != '1) pend_run <= pend_run + 1'b1;
        end else begin
            pend_run <= '0;
        end
    end

    // Cycles protected with both flags clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_run <= '0;
        end else if (wprot_o && !vlow_f && !vbat_f) begin
            if (hold_run != '1) hold_run <= hold_run + 1'b1;
        end else begin
            hold_run <= '0;
        end
    end

    AST_IDLE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wprot_o && vlow_f && !busy_i) |=> wprot_o); // R3

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_run <= PW'(PROTECT_CYC + 1)); // R5

    AST_BAT_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        batsel_o |-> wprot_o); // R7

    AST_BAT_FROM_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batsel_o) |-> $past(wprot_o)); // R7

    AST_BAT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        batsel_o |-> $past(vbat_f)); // R7

    AST_BAT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (batsel_o && !vbat_f) |=> (!batsel_o && wprot_o)); // R8

    AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wprot_o) |-> (hold_run >= RW'(RECOVER_CYC))); // R9

    AST_ODIS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wprot_o) |-> $rose(odis_o)); // R11

endmodule

bind pwrfail_guard pwrfail_guard_checker #(
    .PROTECT_CYC (PROTECT_CYC),
    .RECOVER_CYC (RECOVER_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy_i),
    .vlow_f   (vlow_f),
    .vbat_f   (vbat_f),
    .wprot_o  (wprot_o),
    .odis_o   (odis_o),
    .batsel_o (batsel_o)
);

// File: tb/pwrfail_guard_bench.sv
`timescale 1ns/1ps
module pwrfail_guard_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, vlow, vbat, busy;
    logic wp, od, bs;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    pwrfail_guard #(
        .CLK_HZ     (100_000),
        .PROTECT_US (100),
        .RECOVER_US (400),
        .FILT_LEN   (3)
    ) u_pwrfail_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .vlow_i   (vlow),
        .vbat_i   (vbat),
        .busy_i   (busy),
        .wprot_o  (wp),
        .odis_o   (od),
        .batsel_o (bs)
    );

    typedef struct {
        int    at;
        logic  e_wp;
        logic  e_od;
        logic  e_bs;
        string tag;
    } exp_t;

    exp_t q[$];

    task automatic check3(input string tag, input logic e_wp, input logic e_od, input logic e_bs);
        n_chk++;
        if ({wp, od, bs} !== {e_wp, e_od, e_bs}) begin
            n_err++;
            $display("FAIL %s @cyc %0d: wp/od/bs actual %b%b%b expected %b%b%b",
                     tag, cyc, wp, od, bs, e_wp, e_od, e_bs);
        end
    endtask

    // Driver side: schedule an expectation dt cycles ahead
    task automatic expect_at(input int dt, input logic w, input logic o, input logic b, input string tag);
        exp_t e;
        e.at = cyc + dt; e.e_wp = w; e.e_od = o; e.e_bs = b; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare scheduled items when their cycle comes round
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                check3(q[i].tag, q[i].e_wp, q[i].e_od, q[i].e_bs);
                q.delete(i);
            end
        end
    end

    initial begin
        rst_n = 1'b0; vlow = 1'b0; vbat = 1'b0; busy = 1'b0;
        step(3);
        check3("R2 reset state", 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        expect_at(40, 1, 1, 0, "R2 hold-off after reset");
        expect_at(41, 0, 0, 0, "R2 release after hold-off");
        step(45);

        // R1: two-sample glitch ignored
        vlow = 1'b1;
        expect_at(4, 0, 0, 0, "R1 glitch ignored");
        expect_at(6, 0, 0, 0, "R1 glitch ignored late");
        step(2);
        vlow = 1'b0;
        step(6);

        // R3: low supply with idle bus
        vlow = 1'b1;
        expect_at(3, 0, 0, 0, "R1 filter latency");
        expect_at(4, 1, 1, 0, "R3 idle protect");
        step(6);
        // R9: recovery hold-off
        vlow = 1'b0;
        expect_at(43, 1, 1, 0, "R9 still held");
        expect_at(44, 0, 0, 0, "R9 released");
        step(46);

        // R4: access in flight defers protection
        busy = 1'b1; vlow = 1'b1;
        expect_at(4, 0, 0, 0, "R4 pending");
        expect_at(6, 0, 0, 0, "R4 pending while busy");
        step(6);
        busy = 1'b0;
        expect_at(1, 1, 1, 0, "R4 protect after access end");
        step(2);
        vlow = 1'b0;
        expect_at(44, 0, 0, 0, "R9 release after R4");
        step(46);

        // R5: timeout with access stuck
        busy = 1'b1; vlow = 1'b1;
        expect_at(13, 0, 0, 0, "R5 before timeout");
        expect_at(14, 1, 1, 0, "R5 timeout protect");
        step(16);
        busy = 1'b0;
        // R7: battery select
        vbat = 1'b1;
        expect_at(3, 1, 1, 0, "R7 before battery");
        expect_at(4, 1, 1, 1, "R7 battery selected");
        step(6);
        // R8: back to external power
        vbat = 1'b0;
        expect_at(3, 1, 1, 1, "R8 still battery");
        expect_at(4, 1, 1, 0, "R8 battery released");
        step(6);
        vlow = 1'b0;
        expect_at(43, 1, 1, 0, "R9 held after battery");
        expect_at(44, 0, 0, 0, "R9 released after battery");
        step(46);

        // R6: fast fall forces protection during pending
        busy = 1'b1; vlow = 1'b1;
        step(5);
        vbat = 1'b1;
        expect_at(3, 0, 0, 0, "R6 pending before force");
        expect_at(4, 1, 1, 0, "R6 forced protect");
        expect_at(5, 1, 1, 1, "R7 battery after force");
        step(7);
        busy = 1'b0; vbat = 1'b0; vlow = 1'b0;
        expect_at(4, 1, 1, 0, "R8 battery off");
        expect_at(44, 1, 1, 0, "R9 held after fast fall");
        expect_at(45, 0, 0, 0, "R11 outputs enabled after hold-off");
        step(47);

        // R10: dip during recovery restarts hold-off
        vlow = 1'b1;
        expect_at(4, 1, 1, 0, "R10 protect");
        step(6);
        vlow = 1'b0;
        expect_at(44, 1, 1, 0, "R10 hold-off restarted");
        expect_at(68, 1, 1, 0, "R10 held before new end");
        expect_at(69, 0, 0, 0, "R10 release after new hold-off");
        step(20);
        vlow = 1'b1;
        step(5);
        vlow = 1'b0;
        step(50);

        if (q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 scoreboard: %0d items unchecked, expected 0", q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running, expected done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule